// File: doc/BRIEF.md
# DMA Single-Transfer Bus Master

This block is the bus-facing side of a DMA engine. It takes one transfer request at a time and turns it into a single, non-burst transfer on a 64-bit AHB-Lite style master port. A request carries the address, the direction, the size, the write data, two memory-type codes (one for outer cacheability and one for inner), a privilege bit, an instruction/data bit and a shared flag. The block latches the request, presents address and control in one address-phase cycle, which it holds while the slave stalls, and then drives write data in the data phase that follows.

Alongside the size, the block derives an 8-bit byte-lane mask and a misalignment flag from the low address bits. It translates the two memory-type codes into bus attribute bits: the outer code goes onto the protection output and the inner code onto a sideband output. When the data phase ends, a one-cycle completion pulse returns the read data and the error response. The requester can present the next request in that same cycle, so back-to-back transfers lose no extra cycle.

Top module: `dma_xfer_master`

## Requirements
- R1: While reset is asserted and after it is released, `bus_trans` is 00 (idle), `req_ready` is 1, `done` is 0 and `bus_wdata` is zero.
- R2: `bus_trans` only takes the values 00 (idle) and 10 (non-sequential). It is 10 exactly in the address-phase cycles, which start on the edge after a request is accepted. `bus_burst` is always 000 (single). `bus_size` is `{1'b0, req_size}`, with size codes 0, 1, 2 and 3 meaning 8, 16, 32 and 64 bits. `bus_addr` and `bus_write` carry the latched request.
- R3: A request is accepted only when `req_ready` is 1, which is only when no transfer is in progress. While `bus_ready` is low in the address phase, the address phase and its address and control are held unchanged. Any request presented while a transfer is in progress is ignored.
- R4: Bit i of `bus_lanes` is 1 exactly when off <= i < off + 2^size, where off = `bus_addr[2:0]`. Lanes that would fall beyond lane 7 are dropped.
- R5: `bus_misalign` is 1 exactly when `bus_addr` is not a multiple of 2^size bytes.
- R6: Memory-type code to 3-bit attribute: 0 (strongly ordered) gives 000; 1 (device) gives 001; 2 (noncacheable) gives 010; 3 (write-through, no allocate on write) gives 110; 4 (write-back, no allocate on write) gives 111; 5 (write-back, write allocate) gives 011; codes 6 and 7 give 000. `bus_prot[4:2]` is the attribute of `req_outer`, `bus_prot[1]` is 1 for privileged and 0 for user, and `bus_prot[0]` is 1 for data and 0 for instruction.
- R7: `bus_side[3:1]` is the attribute of `req_inner`, using the R6 mapping. `bus_side[0]` is `req_shared`.
- R8: In the data phase of a write, `bus_wdata` is the latched write data. In all other cycles it is zero.
- R9: On the edge where the data phase ends with `bus_ready` high, `done` rises for exactly one cycle. `done_rdata` is `bus_rdata` and `done_err` is `bus_resp` as sampled at that edge. `req_ready` is 1 in that cycle, so the next request can be accepted there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted when valid |
| req_addr | input | 32 | Byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Size code, 2^code bytes |
| req_wdata | input | 64 | Write data, lane-positioned |
| req_outer | input | 3 | Outer memory-type code |
| req_inner | input | 3 | Inner memory-type code |
| req_priv | input | 1 | 1 = privileged access |
| req_is_data | input | 1 | 1 = data, 0 = instruction |
| req_shared | input | 1 | Region is shared |
| done | output | 1 | Completion pulse |
| done_rdata | output | 64 | Read data of completed transfer |
| done_err | output | 1 | Error response of completed transfer |
| bus_addr | output | 32 | Bus address |
| bus_trans | output | 2 | Transfer type |
| bus_write | output | 1 | Bus direction |
| bus_size | output | 3 | Bus size |
| bus_burst | output | 3 | Burst type, always single |
| bus_prot | output | 5 | Protection attributes |
| bus_side | output | 4 | Inner attribute and shared flag |
| bus_lanes | output | 8 | Byte-lane mask |
| bus_misalign | output | 1 | Misaligned address flag |
| bus_wdata | output | 64 | Write data |
| bus_rdata | input | 64 | Read data |
| bus_ready | input | 1 | Slave ready |
| bus_resp | input | 1 | 1 = error response |

## Verification
Two things can fall in the same cycle: the completion pulse of one transfer and the acceptance of the next request. The bench provokes this by presenting each new request in the very cycle that `done` is high, so the requester chains transfers without a gap. It then checks that the old read data and error flag appear in that cycle and that the new address phase follows on the next edge. Random wait states in both phases, together with a request that changes its fields while a transfer is in progress, check that the held address phase and the completion values belong to the right transfer.

// File: rtl/dma_xm_pkg.sv
package dma_xm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } xm_state_e;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [2:0] BURST_SINGLE = 3'b000;

  typedef enum logic [2:0] {
    MT_STRONG   = 3'd0,
    MT_DEVICE   = 3'd1,
    MT_NOCACHE  = 3'd2,
    MT_WTHRU    = 3'd3,
    MT_WBACK_NA = 3'd4,
    MT_WBACK_WA = 3'd5
  } mem_type_e;

  // memory-type code to bus attribute bits; reserved codes fall back to strongly ordered
  function automatic logic [2:0] attr_bits(input logic [2:0] code);
    logic [2:0] r;
    case (code)
      MT_STRONG:   r = 3'b000;
      MT_DEVICE:   r = 3'b001;
      MT_NOCACHE:  r = 3'b010;
      MT_WTHRU:    r = 3'b110;
      MT_WBACK_NA: r = 3'b111;
      MT_WBACK_WA: r = 3'b011;
      default:     r = 3'b000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dma_xm_ctrl.sv
module dma_xm_ctrl
  import dma_xm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 2,
  parameter int MT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MT_W-1:0]   req_outer,
  input  logic [MT_W-1:0]   req_inner,
  input  logic              req_priv,
  input  logic              req_is_data,
  input  logic              req_shared,
  input  logic              bus_ready,
  input  logic              bus_resp,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              idle,
  output logic              accept,
  output logic              addr_phase,
  output logic              data_phase,
  output logic [ADDR_W-1:0] addr_q,
  output logic              write_q,
  output logic [SIZE_W-1:0] size_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [MT_W-1:0]   outer_q,
  output logic [MT_W-1:0]   inner_q,
  output logic              priv_q,
  output logic              is_data_q,
  output logic              shared_q,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata,
  output logic              done_err
);

  xm_state_e state_q;

  assign idle       = (state_q == ST_IDLE);
  assign addr_phase = (state_q == ST_ADDR);
  assign data_phase = (state_q == ST_DATA);
  assign accept     = idle && req_valid;

  logic addr_done, data_done;
  assign addr_done = addr_phase && bus_ready;
  assign data_done = data_phase && bus_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (accept)    state_q <= ST_ADDR;
        ST_ADDR: if (addr_done) state_q <= ST_DATA;
        ST_DATA: if (data_done) state_q <= ST_IDLE;
        default:                state_q <= ST_IDLE;
      endcase
    end
  end

  // request latch: fields are frozen for the whole transfer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      write_q   <= 1'b0;
      size_q    <= '0;
      wdata_q   <= '0;
      outer_q   <= '0;
      inner_q   <= '0;
      priv_q    <= 1'b0;
      is_data_q <= 1'b0;
      shared_q  <= 1'b0;
    end else if (accept) begin
      addr_q    <= req_addr;
      write_q   <= req_write;
      size_q    <= req_size;
      wdata_q   <= req_wdata;
      outer_q   <= req_outer;
      inner_q   <= req_inner;
      priv_q    <= req_priv;
      is_data_q <= req_is_data;
      shared_q  <= req_shared;
    end
  end

  // completion register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      done_rdata <= '0;
      done_err   <= 1'b0;
    end else begin
      done <= data_done;
      if (data_done) begin
        done_rdata <= bus_rdata;
        done_err   <= bus_resp;
      end
    end
  end

endmodule

// File: rtl/dma_xm_lanes.sv
module dma_xm_lanes #(
  parameter int LANES  = 8,
  parameter int SIZE_W = 2
) (
  input  logic [$clog2(LANES)-1:0] offset,
  input  logic [SIZE_W-1:0]        size,
  output logic [LANES-1:0]         lanes,
  output logic                     misalign
);

  localparam int OFF_W = $clog2(LANES);
  localparam int CNT_W = OFF_W + 1;

  // number of bytes moved for a size code
  function automatic logic [CNT_W-1:0] span_of(input logic [SIZE_W-1:0] sz);
    return CNT_W'(1) << sz;
  endfunction

  // one past the last lane touched (may exceed LANES; the excess is dropped)
  function automatic logic [CNT_W-1:0] end_lane(input logic [OFF_W-1:0] off,
                                                input logic [SIZE_W-1:0] sz);
    return {1'b0, off} + span_of(sz);
  endfunction

  function automatic logic off_misaligned(input logic [OFF_W-1:0] off,
                                          input logic [SIZE_W-1:0] sz);
    logic [CNT_W-1:0] m;
    m = span_of(sz) - CNT_W'(1);
    return ({1'b0, off} & m) != '0;
  endfunction

  logic [CNT_W-1:0] lo_w, hi_w;
  assign lo_w = {1'b0, offset};
  assign hi_w = end_lane(offset, size);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [CNT_W-1:0] IDX = CNT_W'(g);
    assign lanes[g] = (lo_w <= IDX) && (IDX < hi_w);
  end

  assign misalign = off_misaligned(offset, size);

endmodule

// File: rtl/dma_xm_attr.sv
module dma_xm_attr
  import dma_xm_pkg::*;
#(
  parameter int MT_W = 3
) (
  input  logic [MT_W-1:0] outer,
  input  logic [MT_W-1:0] inner,
  input  logic            priv,
  input  logic            is_data,
  input  logic            shared,
  output logic [4:0]      prot,
  output logic [3:0]      side
);

  assign prot = {attr_bits(outer), priv, is_data};
  assign side = {attr_bits(inner), shared};

endmodule

// File: rtl/dma_xfer_master.sv
module dma_xfer_master
  import dma_xm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 64,
  parameter int SIZE_W = 2,
  parameter int MT_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [MT_W-1:0]   req_outer,
  input  logic [MT_W-1:0]   req_inner,
  input  logic              req_priv,
  input  logic              req_is_data,
  input  logic              req_shared,
  output logic              done,
  output logic [DATA_W-1:0] done_rdata,
  output logic              done_err,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_trans,
  output logic              bus_write,
  output logic [2:0]        bus_size,
  output logic [2:0]        bus_burst,
  output logic [4:0]        bus_prot,
  output logic [3:0]        bus_side,
  output logic [DATA_W/8-1:0] bus_lanes,
  output logic              bus_misalign,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  input  logic              bus_resp
);

  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  // internal events, brought out by name for the checker
  logic idle, accept, addr_phase, data_phase;

  logic [ADDR_W-1:0] addr_q;
  logic              write_q, priv_q, is_data_q, shared_q;
  logic [SIZE_W-1:0] size_q;
  logic [DATA_W-1:0] wdata_q;
  logic [MT_W-1:0]   outer_q, inner_q;

  dma_xm_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .MT_W(MT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_write  (req_write),
    .req_size   (req_size),
    .req_wdata  (req_wdata),
    .req_outer  (req_outer),
    .req_inner  (req_inner),
    .req_priv   (req_priv),
    .req_is_data(req_is_data),
    .req_shared (req_shared),
    .bus_ready  (bus_ready),
    .bus_resp   (bus_resp),
    .bus_rdata  (bus_rdata),
    .idle       (idle),
    .accept     (accept),
    .addr_phase (addr_phase),
    .data_phase (data_phase),
    .addr_q     (addr_q),
    .write_q    (write_q),
    .size_q     (size_q),
    .wdata_q    (wdata_q),
    .outer_q    (outer_q),
    .inner_q    (inner_q),
    .priv_q     (priv_q),
    .is_data_q  (is_data_q),
    .shared_q   (shared_q),
    .done       (done),
    .done_rdata (done_rdata),
    .done_err   (done_err)
  );

  dma_xm_lanes #(
    .LANES(LANES), .SIZE_W(SIZE_W)
  ) u_lanes (
    .offset  (addr_q[OFF_W-1:0]),
    .size    (size_q),
    .lanes   (bus_lanes),
    .misalign(bus_misalign)
  );

  dma_xm_attr #(
    .MT_W(MT_W)
  ) u_attr (
    .outer  (outer_q),
    .inner  (inner_q),
    .priv   (priv_q),
    .is_data(is_data_q),
    .shared (shared_q),
    .prot   (bus_prot),
    .side   (bus_side)
  );

  assign req_ready = idle;
  assign bus_addr  = addr_q;
  assign bus_write = write_q;
  assign bus_size  = 3'({1'b0, size_q});
  assign bus_burst = BURST_SINGLE;
  assign bus_trans = addr_phase ? TRANS_NONSEQ : TRANS_IDLE;
  assign bus_wdata = (data_phase && write_q) ? wdata_q : '0;

endmodule

// File: rtl/dma_xm_chk.sv
module dma_xm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        accept,
  input logic        addr_phase,
  input logic        data_phase,
  input logic        done,
  input logic [1:0]  bus_trans,
  input logic [31:0] bus_addr,
  input logic [2:0]  bus_size,
  input logic [7:0]  bus_lanes,
  input logic [4:0]  bus_prot,
  input logic [63:0] bus_wdata,
  input logic        bus_ready
);

  AST_TRANS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_trans == 2'b00) || (bus_trans == 2'b10)); // R2

  AST_ACCEPT_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (addr_phase && bus_trans == 2'b10)); // R2

  AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({req_ready, addr_phase, data_phase}) == 1); // R3

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !bus_ready) |=> (addr_phase && $stable(bus_addr) && $stable(bus_size) && $stable(bus_prot))); // R3

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && bus_addr[2:0] == 3'd0) |-> ($countones(bus_lanes) == (32'd1 << bus_size))); // R4

  AST_LANE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    addr_phase |-> (bus_lanes != 8'd0)); // R4

  AST_WDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !data_phase |-> (bus_wdata == 64'd0)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(data_phase) && $past(bus_ready))); // R9

  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready); // R9

endmodule

bind dma_xfer_master dma_xm_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .accept     (accept),
  .addr_phase (addr_phase),
  .data_phase (data_phase),
  .done       (done),
  .bus_trans  (bus_trans),
  .bus_addr   (bus_addr),
  .bus_size   (bus_size),
  .bus_lanes  (bus_lanes),
  .bus_prot   (bus_prot),
  .bus_wdata  (bus_wdata),
  .bus_ready  (bus_ready)
);

// File: tb/dma_xfer_master_bench.sv
`timescale 1ns/1ps
module dma_xfer_master_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = '0;
  logic [63:0] req_wdata = '0;
  logic [2:0]  req_outer = '0, req_inner = '0;
  logic        req_priv = 1'b0, req_is_data = 1'b0, req_shared = 1'b0;
  logic        done, done_err;
  logic [63:0] done_rdata;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic        bus_write, bus_misalign;
  logic [2:0]  bus_size, bus_burst;
  logic [4:0]  bus_prot;
  logic [3:0]  bus_side;
  logic [7:0]  bus_lanes;
  logic [63:0] bus_wdata;
  logic [63:0] bus_rdata = '0;
  logic        bus_ready = 1'b1;
  logic        bus_resp = 1'b0;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  dma_xfer_master u_dma_xfer_master (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_lanes(input logic [31:0] a, input logic [1:0] sz);
    logic [7:0] s = '0;
    int lo = int'(a[2:0]);
    int n = 1 << sz;
    for (int b = 0; b < 8; b++) if (b >= lo && b < lo + n) s[b] = 1'b1;
    return s;
  endfunction

  function automatic logic exp_mis(input logic [31:0] a, input logic [1:0] sz);
    return (int'(a[2:0]) % (1 << sz)) != 0;
  endfunction

  function automatic logic [2:0] exp_attr(input logic [2:0] k);
    case (k)
      3'd1: return 3'b001;
      3'd2: return 3'b010;
      3'd3: return 3'b110;
      3'd4: return 3'b111;
      3'd5: return 3'b011;
      default: return 3'b000;
    endcase
  endfunction

  // Entered at a negedge with the block idle; returns at the negedge where done is high.
  task automatic xfer(input logic [31:0] a, input logic w, input logic [1:0] sz,
                      input logic [63:0] wd, input logic [2:0] oa, input logic [2:0] ia,
                      input logic pv, input logic dk, input logic sh,
                      input int wa, input int wdw, input logic [63:0] rd, input logic er,
                      input bit poke);
    req_addr = a; req_write = w; req_size = sz; req_wdata = wd;
    req_outer = oa; req_inner = ia; req_priv = pv; req_is_data = dk; req_shared = sh;
    req_valid = 1'b1;
    chk(req_ready == 1'b1, "R9 ready for new request", 64'(req_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    req_valid = poke;
    if (poke) begin req_addr = ~a; req_size = ~sz; req_outer = ~oa; end
    chk(done == 1'b0, "R9 done single cycle", 64'(done), 64'd0);
    chk(bus_trans == 2'b10, "R2 nonseq in address phase", 64'(bus_trans), 64'h2);
    chk(bus_addr == a, "R2 address", 64'(bus_addr), 64'(a));
    chk(bus_write == w, "R2 direction", 64'(bus_write), 64'(w));
    chk(bus_size == {1'b0, sz}, "R2 size", 64'(bus_size), 64'(sz));
    chk(bus_burst == 3'b000, "R2 single burst", 64'(bus_burst), 64'd0);
    chk(req_ready == 1'b0, "R3 busy during transfer", 64'(req_ready), 64'd0);
    chk(bus_lanes == exp_lanes(a, sz), "R4 lanes", 64'(bus_lanes), 64'(exp_lanes(a, sz)));
    chk(bus_misalign == exp_mis(a, sz), "R5 misalign", 64'(bus_misalign), 64'(exp_mis(a, sz)));
    chk(bus_prot == {exp_attr(oa), pv, dk}, "R6 prot", 64'(bus_prot), 64'({exp_attr(oa), pv, dk}));
    chk(bus_side == {exp_attr(ia), sh}, "R7 side", 64'(bus_side), 64'({exp_attr(ia), sh}));
    chk(bus_wdata == 64'd0, "R8 no data in address phase", bus_wdata, 64'd0);
    for (int i = 0; i < wa; i++) begin
      bus_ready = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(bus_trans == 2'b10 && bus_addr == a, "R3 address held", 64'(bus_addr), 64'(a));
      chk(bus_prot == {exp_attr(oa), pv, dk}, "R3 control held", 64'(bus_prot), 64'({exp_attr(oa), pv, dk}));
    end
    bus_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(bus_trans == 2'b00, "R2 idle in data phase", 64'(bus_trans), 64'd0);
    chk(bus_wdata == (w ? wd : 64'd0), "R8 write data", bus_wdata, w ? wd : 64'd0);
    chk(bus_addr == a, "R3 ignored request", 64'(bus_addr), 64'(a));
    bus_rdata = rd; bus_resp = er;
    for (int i = 0; i < wdw; i++) begin
      bus_ready = 1'b0;
      @(posedge clk); @(negedge clk);
      chk(done == 1'b0, "R9 no done while stalled", 64'(done), 64'd0);
      chk(bus_wdata == (w ? wd : 64'd0), "R8 write data held", bus_wdata, w ? wd : 64'd0);
    end
    bus_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    bus_resp = 1'b0; bus_rdata = ~rd;
    chk(done == 1'b1, "R9 done pulse", 64'(done), 64'd1);
    chk(done_rdata == rd, "R9 read data", done_rdata, rd);
    chk(done_err == er, "R9 error flag", 64'(done_err), 64'(er));
    chk(req_ready == 1'b1, "R9 ready with done", 64'(req_ready), 64'd1);
    chk(bus_wdata == 64'd0, "R8 quiet after data phase", bus_wdata, 64'd0);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      chk(bus_trans == 2'b00 && done == 1'b0, "R2 idle between transfers", 64'(bus_trans), 64'd0);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(bus_trans == 2'b00, "R1 reset trans", 64'(bus_trans), 64'd0);
    chk(req_ready == 1'b1, "R1 reset ready", 64'(req_ready), 64'd1);
    chk(done == 1'b0, "R1 reset done", 64'(done), 64'd0);
    chk(bus_wdata == 64'd0, "R1 reset wdata", bus_wdata, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_trans == 2'b00 && req_ready == 1'b1, "R1 after release", 64'(bus_trans), 64'd0);

    // directed corners
    xfer(32'h1000, 1'b1, 2'd3, 64'h0123_4567_89ab_cdef, 3'd4, 3'd5, 1, 1, 1, 0, 0, 64'd0, 0, 0);
    chk(bus_lanes == 8'hff && bus_misalign == 1'b0, "R4 full aligned word", 64'(bus_lanes), 64'hff);
    xfer(32'h2005, 1'b0, 2'd3, 64'd0, 3'd6, 3'd7, 0, 0, 0, 2, 1, 64'hdead_beef_0000_1111, 1, 1);
    gap(1);
    xfer(32'h3006, 1'b1, 2'd2, 64'hffee_0000_0000_0000, 3'd3, 3'd2, 1, 1, 0, 0, 2, 64'd5, 0, 0);
    xfer(32'h3007, 1'b0, 2'd0, 64'd0, 3'd1, 3'd0, 0, 1, 1, 1, 0, 64'h77, 0, 0);
    xfer(32'h3002, 1'b0, 2'd1, 64'd0, 3'd0, 3'd3, 1, 0, 1, 0, 0, 64'h88, 1, 0);
    xfer(32'h3003, 1'b1, 2'd1, 64'h0000_0000_1234_0000, 3'd5, 3'd4, 0, 1, 0, 3, 3, 64'h99, 0, 1);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a  = $urandom;
      logic [1:0]  sz = 2'($urandom_range(0, 3));
      logic [63:0] wd = {$urandom, $urandom};
      logic [63:0] rd = {$urandom, $urandom};
      if ($urandom_range(0, 1) == 0) a = a & ~((32'd1 << sz) - 32'd1);
      xfer(a, 1'($urandom), sz, wd, 3'($urandom), 3'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom),
           $urandom_range(0, 3), $urandom_range(0, 3), rd, 1'($urandom),
           ($urandom_range(0, 4) == 0));
      if ($urandom_range(0, 3) == 0) gap($urandom_range(1, 3));
    end

    gap(2);
    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule